// File: doc/BRIEF.md
# Multi-mode addressable output latch

This block holds eight bits that drive eight low-side switches. A system clock samples all control, select and data inputs through a two-stage synchronizer. Two active-low mode pins, `wipe_n` and `arm_n`, then choose one of four behaviours:

- write one addressed bit,
- freeze everything,
- route the data bit to a single output while the other outputs are off,
- wipe all storage.

A 3-bit select names the output that a write or a route acts on. Each output is given two ways: a switch-on vector, where 1 means the switch conducts, and a drain-level vector, which is its bitwise inverse because a conducting switch pulls its line low.

Software or a sequencer sets the select and data while `arm_n` is high. It then lowers `arm_n` to act on that address. A sticky flag records any change of the select while `arm_n` is low, since such a change can store a bit at the wrong address.

Top module: `addr_out_latch`

## Requirements
- R1: The synchronized pair (`wipe_n`, `arm_n`) selects the mode: (1,0) is write, (1,1) is hold, (0,0) is route and (0,1) is wipe.
- R2: In write mode the storage bit at index `sel` takes `din`, the other seven bits are unchanged, and `sw_on` shows the updated storage.
- R3: In hold mode `sw_on` equals the storage, and neither `sel` nor `din` changes storage or outputs.
- R4: In route mode `sw_on` has only bit `sel` possibly set, equal to `din`, and the other bits are 0. The storage is not altered, so a later hold shows the contents from before the route.
- R5: In wipe mode the storage and `sw_on` become all zero, whatever `sel` and `din` are.
- R6: `sel` is plain binary with its MSB first, and a value n addresses bit n of `sw_on` (0 to 7).
- R7: `drain_lvl` is always the bitwise inverse of `sw_on`.
- R8: An input change applied before rising edge E1 reaches the outputs at rising edge E3. Edges E1 and E2 are the two synchronizer stages, and E3 is the output register.
- R9: `proto_err` sets one edge after the synchronized `sel` changes while the synchronized `arm_n` is 0. It then stays set until reset.
- R10: A synchronous active-high `rst` gives storage 0, `sw_on` = 0x00, `drain_lvl` = 0xFF and `proto_err` = 0. It also loads the synchronizer with hold mode and `sel` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wipe_n | input | 1 | Active-low mode pin, low selects route or wipe |
| arm_n | input | 1 | Active-low mode pin, low selects write or route |
| sel | input | 3 | Output address, binary |
| din | input | 1 | Data bit |
| sw_on | output | 8 | Switch controls, 1 = conducting |
| drain_lvl | output | 8 | Line levels, inverse of `sw_on` |
| proto_err | output | 1 | Sticky flag for a select change while armed |

## Verification
The storage and output assertions assume that `sel` and `din` change together with the mode pins or while `arm_n` is high, so that each synchronized mode acts on one address. The stimulus holds every input combination for at least three clock cycles. It always passes through hold mode with the new address before it lowers `arm_n` again. The one exception is a single deliberate violation that exercises the error flag, and a reset follows it.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {MD_WRITE, MD_HOLD, MD_ROUTE, MD_WIPE} mode_t;

  function automatic mode_t decode_mode(input logic wipe_n, input logic arm_n);
    case ({wipe_n, arm_n})
      2'b10:   return MD_WRITE;
      2'b11:   return MD_HOLD;
      2'b00:   return MD_ROUTE;
      default: return MD_WIPE;
    endcase
  endfunction
endpackage

// File: rtl/al_sync.sv
module al_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/al_store.sv
module al_store
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int SEL_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_t              mode,
  input  logic [SEL_W-1:0]   sel,
  input  logic               din,
  output logic [NUM_OUT-1:0] store_q,
  output logic [NUM_OUT-1:0] store_nxt
);
  always_comb begin
    store_nxt = store_q;
    case (mode)
      MD_WRITE: store_nxt[sel] = din;
      MD_WIPE:  store_nxt = '0;
      default:  store_nxt = store_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) store_q <= '0;
    else     store_q <= store_nxt;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_HOLD) |=> $stable(store_q)); // R3
  AST_ROUTE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ROUTE) |=> $stable(store_q)); // R4
  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WIPE) |=> (store_q == '0)); // R5
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WRITE) |=> ($countones(store_q ^ $past(store_q)) <= 1)); // R2
endmodule

// File: rtl/al_drive.sv
module al_drive
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int SEL_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_t              mode,
  input  logic [SEL_W-1:0]   sel,
  input  logic               din,
  input  logic [NUM_OUT-1:0] store_nxt,
  output logic [NUM_OUT-1:0] sw_on,
  output logic [NUM_OUT-1:0] drain_lvl
);
  logic [NUM_OUT-1:0] routed;
  logic [NUM_OUT-1:0] nxt;

  always_comb begin
    routed      = '0;
    routed[sel] = din;
    nxt = (mode == MD_ROUTE) ? routed : store_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_on     <= '0;
      drain_lvl <= '1;
    end else begin
      sw_on     <= nxt;
      drain_lvl <= ~nxt;
    end
  end

  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_ROUTE) |=> $onehot0(sw_on)); // R4
  AST_WIPE_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WIPE) |=> (sw_on == '0)); // R5
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_HOLD && $past(mode) == MD_HOLD) |=> $stable(sw_on)); // R3
endmodule

// File: rtl/al_monitor.sv
module al_monitor #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_n_s,
  input  logic [SEL_W-1:0] sel_s,
  output logic             err
);
  logic [SEL_W-1:0] sel_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= '0;
      err      <= 1'b0;
    end else begin
      sel_prev <= sel_s;
      if (!arm_n_s && (sel_s != sel_prev)) err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9
endmodule

// File: rtl/addr_out_latch.sv
module addr_out_latch
  import addr_latch_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(NUM_OUT),
  localparam int IN_W  = SEL_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wipe_n,
  input  logic               arm_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               din,
  output logic [NUM_OUT-1:0] sw_on,
  output logic [NUM_OUT-1:0] drain_lvl,
  output logic               proto_err
);
  localparam logic [IN_W-1:0] SYNC_RST = {1'b1, 1'b1, {SEL_W{1'b0}}, 1'b0};

  logic [IN_W-1:0]    in_s;
  logic               wipe_n_s, arm_n_s, din_s;
  logic [SEL_W-1:0]   sel_s;
  mode_t              mode_s;
  logic [NUM_OUT-1:0] store_q, store_nxt;

  al_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({wipe_n, arm_n, sel, din}),
    .q   (in_s)
  );

  assign {wipe_n_s, arm_n_s, sel_s, din_s} = in_s;
  assign mode_s = decode_mode(wipe_n_s, arm_n_s);

  al_store #(.NUM_OUT(NUM_OUT)) u_store (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_s),
    .sel       (sel_s),
    .din       (din_s),
    .store_q   (store_q),
    .store_nxt (store_nxt)
  );

  al_drive #(.NUM_OUT(NUM_OUT)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_s),
    .sel       (sel_s),
    .din       (din_s),
    .store_nxt (store_nxt),
    .sw_on     (sw_on),
    .drain_lvl (drain_lvl)
  );

  al_monitor #(.SEL_W(SEL_W)) u_mon (
    .clk     (clk),
    .rst     (rst),
    .arm_n_s (arm_n_s),
    .sel_s   (sel_s),
    .err     (proto_err)
  );

  AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode_s == MD_HOLD) |=> (sw_on == store_q)); // R3
endmodule

// File: tb/sim_addr_out_latch.sv
module sim_addr_out_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wipe_n = 1'b1, arm_n = 1'b1, din = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] sw_on, drain_lvl;
  logic       proto_err;

  int nvec = 0;
  int nbad = 0;
  logic [7:0] store_m = 8'h00;
  logic [7:0] exp_sw  = 8'h00;
  logic       exp_err = 1'b0;
  logic [2:0] last_sel = 3'd0;

  always #2 clk = ~clk;

  addr_out_latch u0 (
    .clk(clk), .rst(rst), .wipe_n(wipe_n), .arm_n(arm_n),
    .sel(sel), .din(din), .sw_on(sw_on), .drain_lvl(drain_lvl),
    .proto_err(proto_err)
  );

  task automatic chk(input string rq, input logic [7:0] sw_e, input logic err_e);
    nvec++;
    if (sw_on !== sw_e || drain_lvl !== ~sw_e || proto_err !== err_e) begin
      nbad++;
      $display("FAIL %s: sw_on=%b drain=%b err=%b expected sw_on=%b drain=%b err=%b",
               rq, sw_on, drain_lvl, proto_err, sw_e, ~sw_e, err_e);
    end
  endtask

  // Apply inputs at a falling edge; outputs must be old after two rising
  // edges (R8) and new after the third.
  task automatic drive(input logic c, input logic e, input logic [2:0] s,
                       input logic d, input string rq);
    logic [7:0] prev_sw;
    logic       prev_err;
    @(negedge clk);
    wipe_n = c; arm_n = e; sel = s; din = d;
    prev_sw = exp_sw; prev_err = exp_err;
    case ({c, e})
      2'b10: begin store_m[s] = d; exp_sw = store_m; end
      2'b11: exp_sw = store_m;
      2'b00: exp_sw = d ? (8'h01 << s) : 8'h00;
      default: begin store_m = 8'h00; exp_sw = 8'h00; end
    endcase
    if (!e && s != last_sel) exp_err = 1'b1;
    last_sel = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({rq, " R8 before third edge"}, prev_sw, prev_err);
    @(posedge clk);
    @(negedge clk);
    chk(rq, exp_sw, exp_err);
  endtask

  task automatic op(input logic c, input logic e, input logic [2:0] s,
                    input logic d, input string rq);
    drive(1'b1, 1'b1, s, d, "R3 setup hold");
    drive(c, e, s, d, rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wipe_n = 1'b1; arm_n = 1'b1; sel = 3'd0; din = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    store_m = 8'h00; exp_sw = 8'h00; exp_err = 1'b0; last_sel = 3'd0;
    chk("R10 reset state", 8'h00, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    nbad++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R2 R6: write every address
    for (int a = 0; a < 8; a++) op(1'b1, 1'b0, 3'(a), (a % 3) != 0, "R2 R6 write");
    // R3: hold ignores select and data
    for (int a = 0; a < 8; a++) drive(1'b1, 1'b1, 3'(7 - a), a[0], "R3 hold ignores");
    // R4 R6: route every address with both data values
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 2; d++) op(1'b0, 1'b0, 3'(a), d[0], "R4 R6 route");
    drive(1'b1, 1'b1, 3'd3, 1'b1, "R4 storage kept after route");
    // R5: wipe
    op(1'b0, 1'b1, 3'd5, 1'b1, "R5 wipe");
    drive(1'b1, 1'b1, 3'd5, 1'b1, "R5 storage zero after wipe");
    // R2: set all, then clear some bits by writing 0
    for (int a = 0; a < 8; a++) op(1'b1, 1'b0, 3'(a), 1'b1, "R2 write ones");
    for (int a = 0; a < 8; a += 3) op(1'b1, 1'b0, 3'(a), 1'b0, "R2 R7 write zero");
    // R1: each mode in turn on one address
    op(1'b1, 1'b0, 3'd4, 1'b0, "R1 write mode");
    op(1'b1, 1'b1, 3'd4, 1'b1, "R1 hold mode");
    op(1'b0, 1'b0, 3'd4, 1'b1, "R1 route mode");
    op(1'b0, 1'b1, 3'd4, 1'b1, "R1 wipe mode");
    // R9: select change while armed
    op(1'b1, 1'b0, 3'd0, 1'b1, "R9 clean write");
    drive(1'b1, 1'b0, 3'd6, 1'b1, "R9 flag sets");
    drive(1'b1, 1'b1, 3'd2, 1'b0, "R9 flag sticky");
    do_reset();
    drive(1'b1, 1'b1, 3'd1, 1'b0, "R9 flag cleared by reset");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule